// File: doc/BRIEF.md
# Weighted record distributor

This block accepts a single stream of 16-bit tagged words and deals whole records out to two downstream lanes. Each record is a fixed number of data words (50 by default). The split between the lanes follows two weights that are loaded before a run and held constant while it lasts. Set the weights to match how many sorting cells each lane feeds, and each cell receives about the same share of records. A record is never cut between lanes: the lane is chosen when the first word of a record is accepted and stays fixed until the last word.

Words carrying a tag bit of one are commands. A command is not part of any record. It is delivered once to each lane, and it may arrive between records or inside one without disturbing the record framing. The flush command marks the end of a block of records. Besides being broadcast, it returns the weighting pattern to its first position, so the next block starts on lane 0.

All three streams use a valid/ready handshake with no buffering inside the block. A stalled lane holds the input until the word is taken.

Top module: `weighted_distributor`

## Requirements
- R1: After reset neither lane asserts valid while the input is idle, and the first record goes to lane 0 when its weight is nonzero.
- R2: Every data word of a record (REC_WORDS words, with commands not counted) leaves on the lane chosen at its first word, in the order it arrived.
- R3: A data word (tag 0) is offered to exactly one lane, never both.
- R4: Counting records from reset or the last flush, record k goes to lane 0 when k mod (weight0+weight1) is below weight0, and to lane 1 otherwise.
- R5: A lane whose weight is zero never receives a data word. With both weights zero, data words are held (in_ready low) and no lane sees them.
- R6: When the selected lane is not ready, the word waits. Its lane valid stays high with stable data, and no word is lost or duplicated.
- R7: A command word (tag 1) is delivered exactly once to each lane, in stream order. The input accepts it only after both lanes have taken it, and it does not count as a record word.
- R8: A flush (a command whose data bits [15:12] are 4'hF) also restarts the weighting pattern, so the next record is counted as k = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| weight0 | input | WEIGHT_W | Records per pattern sent to lane 0 |
| weight1 | input | WEIGHT_W | Records per pattern sent to lane 1 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_tag | input | 1 | 1 = command word, 0 = record data word |
| in_data | input | 16 | Input word |
| l0_valid | output | 1 | Lane 0 word valid |
| l0_ready | input | 1 | Lane 0 can take a word |
| l0_tag | output | 1 | Lane 0 word tag |
| l0_data | output | 16 | Lane 0 word |
| l1_valid | output | 1 | Lane 1 word valid |
| l1_ready | input | 1 | Lane 1 can take a word |
| l1_tag | output | 1 | Lane 1 word tag |
| l1_data | output | 16 | Lane 1 word |

## Verification
The 4:1 and 2:3 weightings tell a weighted pattern apart from plain alternation, and they show whether lane 0's share comes first in each group. The 2:3 and 1:1 runs use random lane stalls. These show whether a record stays whole and in order when the lanes hold it back, and whether a command placed inside a record reaches both lanes without shifting the record boundary.

A flush placed after three records of a 2:3 pattern separates a restarted pattern from a continued one, because a continued pattern would send the next record to lane 1. The 0:3 and 2:0 weightings check that a zero weight disables its lane. The 0:0 weighting checks that data is held while a flush still passes to both lanes.

// File: rtl/wdist_pkg.sv
package wdist_pkg;

  typedef enum logic {LANE0 = 1'b0, LANE1 = 1'b1} lane_e;

  localparam logic [3:0] FLUSH_OP = 4'hF;

  // Lane for the next record: stay on the current side unless its weight is zero.
  function automatic lane_e pick_lane(lane_e side, logic w0_nz, logic w1_nz);
    if (side == LANE0) return w0_nz ? LANE0 : LANE1;
    return w1_nz ? LANE1 : LANE0;
  endfunction

  function automatic lane_e other_lane(lane_e l);
    return (l == LANE0) ? LANE1 : LANE0;
  endfunction

  function automatic logic is_flush(logic tag, logic [15:0] d);
    return tag && (d[15:12] == FLUSH_OP);
  endfunction

endpackage

// File: rtl/wdist_ratio_seq.sv
module wdist_ratio_seq
  import wdist_pkg::*;
#(
  parameter int WEIGHT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WEIGHT_W-1:0] weight0,
  input  logic [WEIGHT_W-1:0] weight1,
  input  logic                advance,
  input  logic                restart,
  output lane_e               pick,
  output logic                any_lane,
  output lane_e               side,
  output logic [WEIGHT_W-1:0] count
);

  localparam int SUM_W = WEIGHT_W + 1;

  lane_e               side_q;
  logic [WEIGHT_W-1:0] cnt_q;
  logic [WEIGHT_W-1:0] used;
  logic [WEIGHT_W-1:0] wsel;
  logic                group_done;

  always_comb begin
    pick       = pick_lane(side_q, weight0 != '0, weight1 != '0);
    any_lane   = (weight0 != '0) || (weight1 != '0);
    used       = (pick == side_q) ? cnt_q : '0;
    wsel       = (pick == LANE0) ? weight0 : weight1;
    group_done = ({1'b0, used} + SUM_W'(1)) == {1'b0, wsel};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      side_q <= LANE0;
      cnt_q  <= '0;
    end else if (advance) begin
      if (group_done) begin
        side_q <= other_lane(pick);
        cnt_q  <= '0;
      end else begin
        side_q <= pick;
        cnt_q  <= used + WEIGHT_W'(1);
      end
    end
  end

  assign side  = side_q;
  assign count = cnt_q;

endmodule

// File: rtl/wdist_framer.sv
module wdist_framer
  import wdist_pkg::*;
#(
  parameter int REC_WORDS = 50
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  data_fire,
  input  lane_e pick,
  output logic  rec_start,
  output logic  rec_last,
  output lane_e route
);

  localparam int CNT_W = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1;

  logic [CNT_W-1:0] wcnt_q;
  lane_e            route_q;

  assign rec_start = (wcnt_q == '0);
  assign rec_last  = (wcnt_q == CNT_W'(REC_WORDS - 1));
  assign route     = rec_start ? pick : route_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      route_q <= LANE0;
    end else if (data_fire) begin
      wcnt_q <= rec_last ? '0 : wcnt_q + CNT_W'(1);
      if (rec_start) route_q <= pick;
    end
  end

endmodule

// File: rtl/wdist_cmd_bcast.sv
module wdist_cmd_bcast (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic l0_ready,
  input  logic l1_ready,
  output logic l0_send,
  output logic l1_send,
  output logic cmd_ready,
  output logic sent0,
  output logic sent1
);

  logic sent0_q, sent1_q;

  assign l0_send   = cmd_valid && !sent0_q;
  assign l1_send   = cmd_valid && !sent1_q;
  assign cmd_ready = (sent0_q || l0_ready) && (sent1_q || l1_ready);
  assign sent0     = sent0_q;
  assign sent1     = sent1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent0_q <= 1'b0;
      sent1_q <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      sent0_q <= 1'b0;
      sent1_q <= 1'b0;
    end else begin
      sent0_q <= sent0_q || (l0_send && l0_ready);
      sent1_q <= sent1_q || (l1_send && l1_ready);
    end
  end

endmodule

// File: rtl/weighted_distributor.sv
module weighted_distributor
  import wdist_pkg::*;
#(
  parameter int WEIGHT_W  = 4,
  parameter int REC_WORDS = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WEIGHT_W-1:0] weight0,
  input  logic [WEIGHT_W-1:0] weight1,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_tag,
  input  logic [15:0]         in_data,
  output logic                l0_valid,
  input  logic                l0_ready,
  output logic                l0_tag,
  output logic [15:0]         l0_data,
  output logic                l1_valid,
  input  logic                l1_ready,
  output logic                l1_tag,
  output logic [15:0]         l1_data
);

  lane_e               pick, route, side;
  logic                any_lane, rec_start, rec_last;
  logic [WEIGHT_W-1:0] count;
  logic                cmd_valid, cmd_ready, cmd_l0, cmd_l1, sent0, sent1;
  logic                data_valid, lane_ok, data_ready;
  logic                data_fire, cmd_fire, flush_fire, rec_advance;

  assign cmd_valid   = in_valid && in_tag;
  assign data_valid  = in_valid && !in_tag;
  assign lane_ok     = !rec_start || any_lane;
  assign data_ready  = lane_ok && ((route == LANE0) ? l0_ready : l1_ready);
  assign in_ready    = in_tag ? cmd_ready : data_ready;
  assign data_fire   = data_valid && data_ready;
  assign cmd_fire    = cmd_valid && cmd_ready;
  assign flush_fire  = cmd_fire && is_flush(in_tag, in_data);
  assign rec_advance = data_fire && rec_start;

  wdist_ratio_seq #(.WEIGHT_W(WEIGHT_W)) i_ratio_seq (
    .clk(clk), .rst_n(rst_n), .weight0(weight0), .weight1(weight1),
    .advance(rec_advance), .restart(flush_fire), .pick(pick),
    .any_lane(any_lane), .side(side), .count(count)
  );

  wdist_framer #(.REC_WORDS(REC_WORDS)) i_framer (
    .clk(clk), .rst_n(rst_n), .data_fire(data_fire), .pick(pick),
    .rec_start(rec_start), .rec_last(rec_last), .route(route)
  );

  wdist_cmd_bcast i_cmd_bcast (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .l0_ready(l0_ready),
    .l1_ready(l1_ready), .l0_send(cmd_l0), .l1_send(cmd_l1),
    .cmd_ready(cmd_ready), .sent0(sent0), .sent1(sent1)
  );

  assign l0_valid = cmd_l0 || (data_valid && lane_ok && route == LANE0);
  assign l1_valid = cmd_l1 || (data_valid && lane_ok && route == LANE1);
  assign l0_tag   = in_tag;
  assign l1_tag   = in_tag;
  assign l0_data  = in_data;
  assign l1_data  = in_data;

endmodule

// File: rtl/wdist_checker.sv
module wdist_checker
  import wdist_pkg::*;
#(
  parameter int WEIGHT_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [WEIGHT_W-1:0] weight0,
  input logic [WEIGHT_W-1:0] weight1,
  input logic                in_valid,
  input logic                in_tag,
  input logic                l0_valid,
  input logic                l0_ready,
  input logic                l0_tag,
  input logic [15:0]         l0_data,
  input logic                l1_valid,
  input logic                l1_ready,
  input logic                l1_tag,
  input logic [15:0]         l1_data,
  input logic                data_fire,
  input logic                rec_last,
  input lane_e               route,
  input logic                cmd_fire,
  input logic                sent0,
  input logic                sent1,
  input logic                flush_fire,
  input lane_e               side,
  input logic [WEIGHT_W-1:0] count
);

  AST_ROUTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && !rec_last) |=> $stable(route)); // R2

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_tag) |-> !(l0_valid && l1_valid)); // R3

  AST_RATIO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((side == LANE0 && weight0 != '0) |-> count < weight0) and
    ((side == LANE1 && weight1 != '0) |-> count < weight1)); // R4

  AST_ZERO_L0: assert property (@(posedge clk) disable iff (!rst_n)
    (weight0 == '0) |-> !(l0_valid && !l0_tag)); // R5

  AST_ZERO_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (weight1 == '0) |-> !(l1_valid && !l1_tag)); // R5

  AST_HOLD_L0: assert property (@(posedge clk) disable iff (!rst_n)
    (l0_valid && !l0_ready) |=> (l0_valid && $stable(l0_data))); // R6

  AST_HOLD_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_valid && !l1_ready) |=> (l1_valid && $stable(l1_data))); // R6

  AST_CMD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sent0 |-> !l0_valid) and (sent1 |-> !l1_valid)); // R7

  AST_CMD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> (!sent0 && !sent1)); // R7

  AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> (side == LANE0 && count == '0)); // R8

endmodule

bind weighted_distributor wdist_checker #(.WEIGHT_W(WEIGHT_W)) i_wdist_checker (
  .clk(clk), .rst_n(rst_n), .weight0(weight0), .weight1(weight1),
  .in_valid(in_valid), .in_tag(in_tag),
  .l0_valid(l0_valid), .l0_ready(l0_ready), .l0_tag(l0_tag), .l0_data(l0_data),
  .l1_valid(l1_valid), .l1_ready(l1_ready), .l1_tag(l1_tag), .l1_data(l1_data),
  .data_fire(data_fire), .rec_last(rec_last), .route(route),
  .cmd_fire(cmd_fire), .sent0(sent0), .sent1(sent1),
  .flush_fire(flush_fire), .side(side), .count(count)
);

// File: tb/test_weighted_distributor.sv
`timescale 1ns/1ps
module test_weighted_distributor;

  localparam int REC = 50;
  localparam int WW  = 4;
  localparam int MAXW = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WW-1:0] weight0 = '0, weight1 = '0;
  logic in_valid = 1'b0, in_tag = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready;
  logic l0_valid, l0_tag, l1_valid, l1_tag;
  logic [15:0] l0_data, l1_data;
  logic l0_ready = 1'b1, l1_ready = 1'b1;

  always #10 clk = ~clk;

  weighted_distributor #(.WEIGHT_W(WW), .REC_WORDS(REC)) i_weighted_distributor (
    .clk(clk), .rst_n(rst_n), .weight0(weight0), .weight1(weight1),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_data(in_data),
    .l0_valid(l0_valid), .l0_ready(l0_ready), .l0_tag(l0_tag), .l0_data(l0_data),
    .l1_valid(l1_valid), .l1_ready(l1_ready), .l1_tag(l1_tag), .l1_data(l1_data)
  );

  int checks = 0, errors = 0;
  logic finished = 1'b0;
  logic stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [16:0] got0 [MAXW], got1 [MAXW], exp0 [MAXW], exp1 [MAXW];
  int n0 = 0, n1 = 0, e0 = 0, e1 = 0;
  int mrec = 0;
  int rec_id = 0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    l0_ready = stall ? lfsr[0] : 1'b1;
    l1_ready = stall ? lfsr[5] : 1'b1;
  end

  always @(posedge clk) begin
    if (rst_n && l0_valid && l0_ready && n0 < MAXW) begin
      got0[n0] = {l0_tag, l0_data};
      n0++;
    end
    if (rst_n && l1_valid && l1_ready && n1 < MAXW) begin
      got1[n1] = {l1_tag, l1_data};
      n1++;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_reset(input int w0, input int w1);
    @(negedge clk);
    in_valid = 1'b0;
    stall    = 1'b0;
    rst_n    = 1'b0;
    weight0  = WW'(w0);
    weight1  = WW'(w1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mrec  = 0;
  endtask

  task automatic send_word(input logic tag, input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_tag   = tag;
    in_data  = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [15:0] d);
    exp0[e0] = {1'b1, d}; e0++;
    exp1[e1] = {1'b1, d}; e1++;
    if (d[15:12] == 4'hF) mrec = 0;
    send_word(1'b1, d);
  endtask

  // Model of R4: position k in the pattern picks lane 0 when k mod sum < weight0.
  task automatic send_record(input int cmd_at, input logic [15:0] cmd_d);
    int sum, lane;
    sum  = int'(weight0) + int'(weight1);
    lane = ((mrec % sum) < int'(weight0)) ? 0 : 1;
    mrec++;
    for (int i = 0; i < REC; i++) begin
      logic [15:0] w;
      if (i == cmd_at) send_cmd(cmd_d);
      w = {8'(rec_id), 8'(i)};
      if (lane == 0) begin exp0[e0] = {1'b0, w}; e0++; end
      else begin exp1[e1] = {1'b0, w}; e1++; end
      send_word(1'b0, w);
    end
    rec_id++;
  endtask

  task automatic drain_compare(input string req, input int s0, input int s1);
    int bad, first;
    for (int t = 0; t < 4000 && (n0 < e0 || n1 < e1); t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n0 == e0, {req, " lane0 word count"}, n0, e0);
    check(n1 == e1, {req, " lane1 word count"}, n1, e1);
    bad = 0; first = -1;
    for (int i = s0; i < e0 && i < n0; i++)
      if (got0[i] !== exp0[i]) begin bad++; if (first < 0) first = i; end
    if (first >= 0) check(1'b0, {req, " lane0 word"}, int'(got0[first]), int'(exp0[first]));
    else check(1'b1, req, 0, 0);
    bad = 0; first = -1;
    for (int i = s1; i < e1 && i < n1; i++)
      if (got1[i] !== exp1[i]) begin bad++; if (first < 0) first = i; end
    if (first >= 0) check(1'b0, {req, " lane1 word"}, int'(got1[first]), int'(exp1[first]));
    else check(1'b1, req, 0, 0);
  endtask

  task automatic test_reset;
    int s0, s1;
    do_reset(4, 1);
    @(negedge clk); #1;
    check(l0_valid == 1'b0, "R1 lane0 idle after reset", int'(l0_valid), 0);
    check(l1_valid == 1'b0, "R1 lane1 idle after reset", int'(l1_valid), 0);
    s0 = n0; s1 = n1;
    send_record(-1, 16'h0);
    drain_compare("R1 first record on lane0", s0, s1);
    check(n0 - s0 == REC, "R1 first record size on lane0", n0 - s0, REC);
  endtask

  task automatic test_ratio_4_1;
    int s0, s1;
    do_reset(4, 1);
    s0 = n0; s1 = n1;
    for (int r = 0; r < 10; r++) send_record(-1, 16'h0);
    drain_compare("R4 R2 ratio 4:1", s0, s1);
    check(n1 - s1 == 2 * REC, "R4 lane1 share 4:1", n1 - s1, 2 * REC);
  endtask

  task automatic test_ratio_2_3_stall;
    int s0, s1;
    do_reset(2, 3);
    stall = 1'b1;
    s0 = n0; s1 = n1;
    for (int r = 0; r < 10; r++) send_record(-1, 16'h0);
    drain_compare("R6 R2 ratio 2:3 with stalls", s0, s1);
    stall = 1'b0;
  endtask

  task automatic test_cmd_mid;
    int s0, s1;
    do_reset(1, 1);
    stall = 1'b1;
    s0 = n0; s1 = n1;
    send_record(-1, 16'h0);
    send_record(20, 16'h1234);
    send_record(-1, 16'h0);
    send_record(0, 16'h2001);
    drain_compare("R7 command inside record", s0, s1);
    stall = 1'b0;
  endtask

  task automatic test_flush;
    int s0, s1;
    do_reset(2, 3);
    s0 = n0; s1 = n1;
    for (int r = 0; r < 3; r++) send_record(-1, 16'h0);
    send_cmd(16'hF000);
    send_record(-1, 16'h0);
    send_record(-1, 16'h0);
    drain_compare("R8 flush restarts pattern", s0, s1);
    check(n0 - s0 == 4 * REC + 1, "R8 lane0 after flush", n0 - s0, 4 * REC + 1);
  endtask

  task automatic test_zero_weight;
    int s0, s1;
    do_reset(0, 3);
    s0 = n0; s1 = n1;
    for (int r = 0; r < 4; r++) send_record(-1, 16'h0);
    drain_compare("R5 weight0 zero", s0, s1);
    check(n0 == s0, "R5 lane0 unused", n0 - s0, 0);
    do_reset(2, 0);
    s0 = n0; s1 = n1;
    for (int r = 0; r < 3; r++) send_record(-1, 16'h0);
    drain_compare("R5 weight1 zero", s0, s1);
    check(n1 == s1, "R5 lane1 unused", n1 - s1, 0);
  endtask

  task automatic test_both_zero;
    int s0, s1;
    do_reset(0, 0);
    s0 = n0; s1 = n1;
    @(negedge clk);
    in_valid = 1'b1; in_tag = 1'b0; in_data = 16'h5A5A;
    repeat (8) @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R5 data held with both weights zero", int'(in_ready), 0);
    check(!l0_valid && !l1_valid, "R5 no lane offered", int'(l0_valid) + int'(l1_valid), 0);
    check(n0 == s0 && n1 == s1, "R5 no words delivered", (n0 - s0) + (n1 - s1), 0);
    in_valid = 1'b0;
    send_cmd(16'hF00F);
    drain_compare("R7 flush broadcast with both weights zero", s0, s1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_ratio_4_1();
    test_ratio_2_3_stall();
    test_cmd_mid();
    test_flush();
    test_zero_weight();
    test_both_zero();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule